// File: doc/BRIEF.md
# Packed Byte and 24-bit Multiply Unit

This unit is the integer part of a multiply-side datapath. Each cycle it takes two 32-bit operands and a 3-bit operation code. It returns a 32-bit result and three condition flags: zero, negative and carry. One mode is an unsigned multiply of the low 24 bits of each operand. The other modes treat each operand as four independent unsigned bytes. On those bytes the unit offers saturating add, saturating subtract, minimum, maximum, and a rounded multiply in which 255 stands for 1.0.

The unit is combinational. By default one register stage sits on the result and flags, which gives one cycle of latency. Setting `REG_OUT` to 0 removes that stage. In that case the outputs follow the inputs within the same cycle.

Operation codes: 0 = 24-bit multiply, 1 = byte saturating add, 2 = byte saturating subtract, 3 = byte minimum, 4 = byte maximum, 5 = byte normalized multiply, 6 and 7 = unused.

Top module: `lane_mul_unit`

## Requirements
- R1: With op 0, the result is the low 32 bits of the unsigned product of bits [23:0] of each operand. Bits [31:24] of both operands have no effect.
- R2: With op 0, C is 1 exactly when the full product is greater than 0xFFFFFF.
- R3: With op 1, each byte lane i (bits [8i+7:8i]) gives min(a+b, 255). No carry passes into the next lane.
- R4: With op 2, each lane gives a-b when a >= b and 0 otherwise. No borrow passes into the next lane.
- R5: With op 3 each lane gives the smaller of its two unsigned bytes. With op 4 each lane gives the larger.
- R6: With op 5, each lane gives floor((a*b + 127) / 255). So 255 with 255 gives 255, and 0 with any value gives 0.
- R7: For ops 1 to 5, C is 0.
- R8: For every op, Z is 1 exactly when all 32 result bits are 0, and N equals result bit 31.
- R9: Ops 6 and 7 give result 0 with Z=1, N=0 and C=0.
- R10: With `REG_OUT`=1, the result and flags appear one clock after the inputs. While reset is asserted (rst_n low), the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_i | input | 3 | Operation select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_o | output | 32 | Result word |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag (result bit 31) |
| flag_c_o | output | 1 | Carry flag |

## Verification
The cases hardest to reach are the lane edges: one lane saturates or clamps while its neighbour sits just below its own limit. A leak across lanes only shows up in that situation. The stimulus sweeps every value of one lane against an evenly spaced set of values that includes 0 and 255. It puts different arrangements of those two values in the four lanes, so that limit and non-limit lanes sit side by side in every operation. The 24-bit multiply is driven with corner products around 0xFFFFFF and with pseudo-random words whose top bytes are deliberately non-zero.

// File: rtl/lane_mul_unit.sv
`timescale 1ns/1ps
module lane_mul_unit #(
  parameter int LANE_W  = 8,
  parameter int LANES   = 4,
  parameter int MUL_W   = 24,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                op_i,
  input  logic [LANE_W*LANES-1:0]   a_i,
  input  logic [LANE_W*LANES-1:0]   b_i,
  output logic [LANE_W*LANES-1:0]   res_o,
  output logic                      flag_z_o,
  output logic                      flag_n_o,
  output logic                      flag_c_o
);
  localparam int W    = LANE_W * LANES;
  localparam int PW   = 2 * MUL_W;
  localparam int RW   = 2 * LANE_W + 1;
  localparam int LMAX = (1 << LANE_W) - 1;
  localparam int HALF = LMAX >> 1;

  localparam logic [2:0] OP_MUL24 = 3'd0;
  localparam logic [2:0] OP_ADDS  = 3'd1;
  localparam logic [2:0] OP_SUBS  = 3'd2;
  localparam logic [2:0] OP_MINU  = 3'd3;
  localparam logic [2:0] OP_MAXU  = 3'd4;
  localparam logic [2:0] OP_MULN  = 3'd5;

  logic [W-1:0]  adds_w, subs_w, min_w, max_w, muln_w;
  logic [PW-1:0] mprod;
  logic [W-1:0]  res_c;
  logic          c_c, z_c, n_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    logic [LANE_W:0]   sum;
    logic [RW-1:0]     rnd;
    assign la  = a_i[g*LANE_W +: LANE_W];
    assign lb  = b_i[g*LANE_W +: LANE_W];
    assign sum = {1'b0, la} + {1'b0, lb};
    assign rnd = RW'({{LANE_W{1'b0}}, la} * {{LANE_W{1'b0}}, lb}) + RW'(HALF);
    assign adds_w[g*LANE_W +: LANE_W] = sum[LANE_W] ? LANE_W'(LMAX) : sum[LANE_W-1:0];
    assign subs_w[g*LANE_W +: LANE_W] = (la >= lb) ? la - lb : '0;
    assign min_w[g*LANE_W +: LANE_W]  = (la < lb) ? la : lb;
    assign max_w[g*LANE_W +: LANE_W]  = (la < lb) ? lb : la;
    assign muln_w[g*LANE_W +: LANE_W] = LANE_W'(rnd / RW'(LMAX));
  end

  assign mprod = {{(PW-MUL_W){1'b0}}, a_i[MUL_W-1:0]} *
                 {{(PW-MUL_W){1'b0}}, b_i[MUL_W-1:0]};

  always_comb begin
    c_c = 1'b0;
    case (op_i)
      OP_MUL24: begin
        res_c = mprod[W-1:0];
        c_c   = |mprod[PW-1:MUL_W];
      end
      OP_ADDS: res_c = adds_w;
      OP_SUBS: res_c = subs_w;
      OP_MINU: res_c = min_w;
      OP_MAXU: res_c = max_w;
      OP_MULN: res_c = muln_w;
      default: res_c = '0;
    endcase
  end

  assign z_c = (res_c == '0);
  assign n_c = res_c[W-1];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_o    <= '0;
        flag_z_o <= 1'b0;
        flag_n_o <= 1'b0;
        flag_c_o <= 1'b0;
      end else begin
        res_o    <= res_c;
        flag_z_o <= z_c;
        flag_n_o <= n_c;
        flag_c_o <= c_c;
      end
    end
  end else begin : g_comb
    assign res_o    = res_c;
    assign flag_z_o = z_c;
    assign flag_n_o = n_c;
    assign flag_c_o = c_c;
  end
endmodule

// File: rtl/lane_mul_unit_chk.sv
`timescale 1ns/1ps
module lane_mul_unit_chk #(
  parameter int LANE_W  = 8,
  parameter int LANES   = 4,
  parameter int MUL_W   = 24,
  parameter bit REG_OUT = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              op_i,
  input logic [LANE_W*LANES-1:0] a_i,
  input logic [LANE_W*LANES-1:0] b_i,
  input logic [LANE_W*LANES-1:0] res_o,
  input logic                    flag_z_o,
  input logic                    flag_n_o,
  input logic                    flag_c_o
);
  localparam int W = LANE_W * LANES;

  logic [2:0]   op_v;
  logic [W-1:0] a_v, b_v;
  logic         armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  if (REG_OUT) begin : g_view
    always_ff @(posedge clk) begin
      op_v <= op_i;
      a_v  <= a_i;
      b_v  <= b_i;
    end
  end else begin : g_view
    assign op_v = op_i;
    assign a_v  = a_i;
    assign b_v  = b_i;
  end

  // R8
  p_zero_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (flag_z_o == (res_o == '0)));
  p_neg_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (flag_n_o == res_o[W-1]));
  // R7
  p_c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && op_v >= 3'd1 && op_v <= 3'd5) |-> !flag_c_o);
  // R2
  p_mul_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && op_v == 3'd0 && (a_v[MUL_W-1:0] == '0 || b_v[MUL_W-1:0] == '0))
      |-> (!flag_c_o && flag_z_o));
  // R9
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && op_v >= 3'd6) |-> (res_o == '0 && !flag_c_o));

  for (genvar g = 0; g < LANES; g++) begin : g_lchk
    logic [LANE_W-1:0] la, lb, lr;
    assign la = a_v[g*LANE_W +: LANE_W];
    assign lb = b_v[g*LANE_W +: LANE_W];
    assign lr = res_o[g*LANE_W +: LANE_W];
    // R3
    p_adds_ge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && op_v == 3'd1) |-> (lr >= la && lr >= lb));
    // R4
    p_subs_le_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && op_v == 3'd2) |-> (lr <= la));
    // R5
    p_min_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && op_v == 3'd3) |-> ((lr == la || lr == lb) && lr <= la && lr <= lb));
    p_max_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && op_v == 3'd4) |-> ((lr == la || lr == lb) && lr >= la && lr >= lb));
    // R6
    p_muln_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && op_v == 3'd5 && lb == '1) |-> (lr == la));
  end
endmodule

bind lane_mul_unit lane_mul_unit_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .MUL_W(MUL_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .res_o(res_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_c_o(flag_c_o)
);

// File: tb/test_lane_mul_unit.sv
`timescale 1ns/1ps
module test_lane_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res;
  logic        fz, fn, fc;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  lane_mul_unit i_lane_mul_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .res_o(res), .flag_z_o(fz), .flag_n_o(fn), .flag_c_o(fc)
  );

  function automatic logic [7:0] lane_ref(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y);
    int s;
    case (o)
      3'd1: begin s = int'(x) + int'(y); return (s > 255) ? 8'd255 : 8'(s); end
      3'd2: begin s = int'(x) - int'(y); return (s < 0) ? 8'd0 : 8'(s); end
      3'd3: return (x < y) ? x : y;
      3'd4: return (x > y) ? x : y;
      3'd5: begin s = (int'(x) * int'(y) + 127) / 255; return 8'(s); end
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (op %0d a %h b %h)", tag, got, exp, op, a, b);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er;
    logic [47:0] p;
    logic        ec;
    string       tag;
    @(negedge clk);
    op = o; a = x; b = y;
    ec = 1'b0;
    if (o == 3'd0) begin
      p  = {24'd0, x[23:0]} * {24'd0, y[23:0]};
      er = p[31:0];
      ec = (p > 48'hFFFFFF);
      tag = "R1";
    end else if (o <= 3'd5) begin
      for (int l = 0; l < 4; l++) er[8*l +: 8] = lane_ref(o, x[8*l +: 8], y[8*l +: 8]);
      case (o)
        3'd1: tag = "R3";
        3'd2: tag = "R4";
        3'd5: tag = "R6";
        default: tag = "R5";
      endcase
    end else begin
      er = '0;
      tag = "R9";
    end
    @(negedge clk);
    check(tag, res, er);
    check((o == 3'd0) ? "R8 R2" : "R8 R7", {29'd0, fz, fn, fc}, {29'd0, (er == 0), er[31], ec});
  endtask

  initial begin
    logic [31:0] s;
    logic [7:0]  bv;
    // R10: reset state
    #1;
    check("R10", {res[31:0]}, 32'd0);
    check("R10", {29'd0, fz, fn, fc}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: latency, output holds until the edge
    apply(3'd1, 32'h01020304, 32'h01010101);
    @(negedge clk);
    op = 3'd1; a = 32'hFFFFFFFF; b = 32'hFFFFFFFF;
    #1 check("R10", res, 32'h02030405);
    @(negedge clk);
    check("R10", res, 32'hFFFFFFFF);
    // R1 R2 corners
    apply(3'd0, 32'h00FFFFFF, 32'h00000001);
    apply(3'd0, 32'hAB001000, 32'hCD001000);
    apply(3'd0, 32'h00001000, 32'h00000FFF);
    apply(3'd0, 32'h00FFFFFF, 32'h00FFFFFF);
    apply(3'd0, 32'hFF000000, 32'h12345678);
    apply(3'd0, 32'h00800000, 32'h00000100);
    // R1 R2 pseudo-random with top bytes set
    s = 32'h1234ABCD;
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] x, y;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); x = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); y = s;
      if (k % 3 == 0) y = y >> 12;
      apply(3'd0, x, y);
    end
    // R3 R4 R5 R6 R7 R8: lane sweeps with mixed lane arrangements
    for (int o = 1; o <= 5; o++)
      for (int ia = 0; ia < 256; ia++)
        for (int jb = 0; jb <= 32; jb++) begin
          logic [7:0] av;
          av = 8'(ia);
          bv = (jb == 32) ? 8'd255 : 8'(jb * 8);
          apply(3'(o), {av ^ 8'h5A, bv, ~av, av}, {bv ^ 8'hA5, av, bv, bv});
        end
    // R6 named corners
    apply(3'd5, 32'hFF00FF80, 32'hFFFFFF02);
    apply(3'd5, 32'hFFFFFFFF, 32'hFFFFFFFF);
    // R9 unused codes
    apply(3'd6, 32'hFFFFFFFF, 32'h12345678);
    apply(3'd7, 32'h80808080, 32'h01010101);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule